// File: doc/BRIEF.md
# I2C Bus-Clear Recovery Sequencer

This block releases an I2C bus that a target device has left stuck, usually with SDA held low part-way through a byte. On a request it takes over the open-drain enables of SCL and SDA and runs a fixed recovery pattern. First it forces not-acknowledge so that SDA is released. Then it clocks SCL through nine low/high pulses, each phase lasting a programmable number of microseconds. Last it forms a STOP condition: SDA is pulled low while SCL is low, SCL is released, and then SDA is released.

A sequence starts on a one-cycle start request or by itself. It starts by itself when the bus-busy indication from the bus monitor stays high for a programmable time while the sequencer is idle. At the end of every sequence the block samples bus-busy. If the bus is free the attempt counted as a success. If the bus is still busy the attempt counted as a failure. The consecutive-failure count limits how many automatic retries run. Once the limit is used up, the next expired busy window raises a timeout error instead of another attempt. A one-cycle done pulse marks the end of each sequence. One cycle later a re-initialise request tells the host controller to go back through its reset-and-configure steps. All timing comes from the system clock through a parameter giving clock cycles per microsecond.

Top module: `i2c_busclr`

## Requirements
- R1: After reset every output is 0: nack_o, scl_oe_o, sda_oe_o, done_o, reinit_o, timeout_err_o, and fail_cnt_o.
- R2: A start_i sampled high while idle sets nack_o on the next clock edge. nack_o stays high until the sequence ends. For the first phase both enables stay 0 (SDA and SCL released).
- R3: After the first phase, scl_oe_o is 1 (SCL low) for one phase and then 0 (SCL released) for one phase, repeated exactly PULSES times (9 by default). Every phase lasts PHASE_US*CLK_PER_US clock cycles.
- R4: After the last pulse comes the STOP. For one phase scl_oe_o=1 and sda_oe_o=1. For one phase scl_oe_o=0 and sda_oe_o=1. For one phase both are 0. sda_oe_o is never 1 outside these two STOP phases.
- R5: done_o is high for exactly one cycle, on the edge after the last STOP phase ends. nack_o falls on that same edge. reinit_o is high for exactly the following cycle.
- R6: A start_i that arrives while a sequence is running is ignored. The running sequence keeps its timing, and no second sequence follows it.
- R7: At the end of each sequence bus_busy_i is sampled. If it is high, fail_cnt_o increments, saturating at MAX_RETRY+1. If it is low, fail_cnt_o returns to 0. fail_cnt_o changes only on the edge that raises done_o.
- R8: While idle, a sequence starts by itself when bus_busy_i has been high for TIMEOUT_US*CLK_PER_US consecutive cycles, provided fail_cnt_o is at most MAX_RETRY. The busy window restarts whenever bus_busy_i is low or a sequence is running.
- R9: If that window expires with fail_cnt_o equal to MAX_RETRY+1, no sequence starts and timeout_err_o goes high. timeout_err_o clears on the edge after bus_busy_i is seen low, or when a sequence is launched, and it is never high while nack_o is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Request a recovery sequence (sampled while idle) |
| bus_busy_i | input | 1 | Bus-busy indication from the bus monitor |
| nack_o | output | 1 | Force not-acknowledge in the host controller during recovery |
| scl_oe_o | output | 1 | Open-drain SCL enable, 1 pulls SCL low |
| sda_oe_o | output | 1 | Open-drain SDA enable, 1 pulls SDA low |
| done_o | output | 1 | One-cycle pulse at the end of a sequence |
| reinit_o | output | 1 | One-cycle request, after done_o, to re-run controller reset and configuration |
| timeout_err_o | output | 1 | Busy window expired with retries exhausted |
| fail_cnt_o | output | ATT_W | Consecutive failed attempts, saturating at MAX_RETRY+1 |

## Verification
Counting the start edge as edge 1, every output is registered, so after edge n the sequencer sits in phase (n-1)/P, where P is the phase length in cycles. The bench compares nack_o, scl_oe_o and sda_oe_o against that formula on the falling edge after every edge of the sequence. It expects done_o and the new fail_cnt_o after edge 22P+1, and reinit_o after edge 22P+2. An automatic launch is due on the TIMEOUT_US*CLK_PER_US-th edge that sees bus_busy_i high in idle. The bench checks that nack_o is still low one edge earlier and high on that edge. The timeout error is checked in the same way. The error clear is checked one edge after bus_busy_i drops.

// File: rtl/i2c_busclr_pkg.sv
package i2c_busclr_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_REL   = 3'd1,
    ST_LOW   = 3'd2,
    ST_HIGH  = 3'd3,
    ST_PLOW  = 3'd4,
    ST_PHIGH = 3'd5,
    ST_PREL  = 3'd6,
    ST_FIN   = 3'd7
  } seq_state_t;
endpackage

// File: rtl/i2c_busclr_tick.sv
module i2c_busclr_tick #(
  parameter int CLK_PER_US = 100
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  output logic tick
);
  localparam int W = $clog2(CLK_PER_US + 1);
  logic [W-1:0] div_q;

  assign tick = (div_q == W'(CLK_PER_US - 1));

  always_ff @(posedge clk) begin
    if (rst || clr) div_q <= '0;
    else if (tick)  div_q <= '0;
    else            div_q <= div_q + 1'b1;
  end
endmodule

// File: rtl/i2c_busclr_watch.sv
module i2c_busclr_watch #(
  parameter int TIMEOUT_US = 1000000
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic tick,
  output logic expire
);
  localparam int W = $clog2(TIMEOUT_US + 1);
  logic [W-1:0] us_q;

  assign expire = tick && (us_q == W'(TIMEOUT_US - 1));

  always_ff @(posedge clk) begin
    if (rst || clr) us_q <= '0;
    else if (expire) us_q <= '0;
    else if (tick)   us_q <= us_q + 1'b1;
  end
endmodule

// File: rtl/i2c_busclr_fsm.sv
module i2c_busclr_fsm
  import i2c_busclr_pkg::*;
#(
  parameter int PHASE_CYC = 2000,
  parameter int PULSES    = 9,
  parameter int MAX_RETRY = 2,
  parameter int ATT_W     = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic             expire_i,
  input  logic             bus_busy_i,
  output logic             idle_o,
  output logic             nack_o,
  output logic             scl_oe_o,
  output logic             sda_oe_o,
  output logic             done_o,
  output logic             reinit_o,
  output logic             timeout_err_o,
  output logic [ATT_W-1:0] fail_cnt_o
);
  localparam int PH_W = $clog2(PHASE_CYC + 1);
  localparam int PL_W = $clog2(PULSES + 1);
  localparam logic [ATT_W-1:0] SAT = ATT_W'(MAX_RETRY + 1);

  seq_state_t state, nxt;
  logic [PH_W-1:0] ph_q;
  logic [PL_W-1:0] pl_q;
  logic phase_end, launch, finishing;

  assign phase_end = (ph_q == PH_W'(PHASE_CYC - 1));
  assign idle_o    = (state == ST_IDLE);
  assign launch    = idle_o && (start_i || (expire_i && fail_cnt_o < SAT));
  assign finishing = (state == ST_PREL) && phase_end;

  always_comb begin
    nxt = state;
    unique case (state)
      ST_IDLE:  if (launch) nxt = ST_REL;
      ST_REL:   if (phase_end) nxt = ST_LOW;
      ST_LOW:   if (phase_end) nxt = ST_HIGH;
      ST_HIGH:  if (phase_end) nxt = (pl_q == PL_W'(PULSES - 1)) ? ST_PLOW : ST_LOW;
      ST_PLOW:  if (phase_end) nxt = ST_PHIGH;
      ST_PHIGH: if (phase_end) nxt = ST_PREL;
      ST_PREL:  if (phase_end) nxt = ST_FIN;
      ST_FIN:   nxt = ST_IDLE;
      default:  nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state         <= ST_IDLE;
      ph_q          <= '0;
      pl_q          <= '0;
      nack_o        <= 1'b0;
      scl_oe_o      <= 1'b0;
      sda_oe_o      <= 1'b0;
      done_o        <= 1'b0;
      reinit_o      <= 1'b0;
      timeout_err_o <= 1'b0;
      fail_cnt_o    <= '0;
    end else begin
      state    <= nxt;
      ph_q     <= (nxt != state) ? '0 : ph_q + 1'b1;
      if (state == ST_IDLE) pl_q <= '0;
      else if (state == ST_HIGH && phase_end) pl_q <= pl_q + 1'b1;
      nack_o   <= (nxt != ST_IDLE) && (nxt != ST_FIN);
      scl_oe_o <= (nxt == ST_LOW) || (nxt == ST_PLOW);
      sda_oe_o <= (nxt == ST_PLOW) || (nxt == ST_PHIGH);
      done_o   <= (nxt == ST_FIN);
      reinit_o <= done_o;
      if (finishing) begin
        if (!bus_busy_i)        fail_cnt_o <= '0;
        else if (fail_cnt_o < SAT) fail_cnt_o <= fail_cnt_o + 1'b1;
      end
      if (launch || !bus_busy_i) timeout_err_o <= 1'b0;
      else if (idle_o && expire_i && fail_cnt_o == SAT) timeout_err_o <= 1'b1;
    end
  end
endmodule

// File: rtl/i2c_busclr.sv
module i2c_busclr #(
  parameter int CLK_PER_US = 100,
  parameter int PHASE_US   = 20,
  parameter int PULSES     = 9,
  parameter int TIMEOUT_US = 1000000,
  parameter int MAX_RETRY  = 2,
  parameter int ATT_W      = $clog2(MAX_RETRY + 2)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic             bus_busy_i,
  output logic             nack_o,
  output logic             scl_oe_o,
  output logic             sda_oe_o,
  output logic             done_o,
  output logic             reinit_o,
  output logic             timeout_err_o,
  output logic [ATT_W-1:0] fail_cnt_o
);
  localparam int PHASE_CYC = PHASE_US * CLK_PER_US;

  logic idle, us_tick, expire, win_clr;

  assign win_clr = !bus_busy_i || !idle;

  i2c_busclr_tick #(.CLK_PER_US(CLK_PER_US)) u_tick (
    .clk(clk), .rst(rst), .clr(win_clr), .tick(us_tick)
  );

  i2c_busclr_watch #(.TIMEOUT_US(TIMEOUT_US)) u_watch (
    .clk(clk), .rst(rst), .clr(win_clr), .tick(us_tick), .expire(expire)
  );

  i2c_busclr_fsm #(
    .PHASE_CYC(PHASE_CYC), .PULSES(PULSES),
    .MAX_RETRY(MAX_RETRY), .ATT_W(ATT_W)
  ) u_fsm (
    .clk(clk), .rst(rst), .start_i(start_i), .expire_i(expire),
    .bus_busy_i(bus_busy_i), .idle_o(idle), .nack_o(nack_o),
    .scl_oe_o(scl_oe_o), .sda_oe_o(sda_oe_o), .done_o(done_o),
    .reinit_o(reinit_o), .timeout_err_o(timeout_err_o),
    .fail_cnt_o(fail_cnt_o)
  );
endmodule

// File: rtl/i2c_busclr_chk.sv
module i2c_busclr_chk #(
  parameter int MAX_RETRY = 2,
  parameter int ATT_W     = 2
) (
  input logic             clk,
  input logic             rst,
  input logic             nack_o,
  input logic             scl_oe_o,
  input logic             sda_oe_o,
  input logic             done_o,
  input logic             timeout_err_o,
  input logic [ATT_W-1:0] fail_cnt_o
);
  // R5: done is a single-cycle pulse
  a_r5_done_single: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);
  // R5: the forced not-acknowledge ends together with done
  a_r5_nack_ends_with_done: assert property (@(posedge clk) disable iff (rst)
    $fell(nack_o) |-> done_o);
  // R3: SCL is only pulled while a sequence is active
  a_r3_scl_in_seq: assert property (@(posedge clk) disable iff (rst)
    scl_oe_o |-> nack_o);
  // R4: SDA is only pulled during the STOP phases of a sequence
  a_r4_sda_in_seq: assert property (@(posedge clk) disable iff (rst)
    sda_oe_o |-> nack_o);
  // R7: failure count saturates
  a_r7_cnt_bound: assert property (@(posedge clk) disable iff (rst)
    fail_cnt_o <= ATT_W'(MAX_RETRY + 1));
  // R7: failure count moves only at the end of a sequence
  a_r7_cnt_on_done: assert property (@(posedge clk) disable iff (rst)
    !$stable(fail_cnt_o) |-> done_o);
  // R9: timeout error and an active sequence exclude each other
  a_r9_err_excl: assert property (@(posedge clk) disable iff (rst)
    timeout_err_o |-> !nack_o);
endmodule

bind i2c_busclr i2c_busclr_chk #(.MAX_RETRY(MAX_RETRY), .ATT_W(ATT_W)) u_chk (
  .clk(clk), .rst(rst), .nack_o(nack_o), .scl_oe_o(scl_oe_o),
  .sda_oe_o(sda_oe_o), .done_o(done_o), .timeout_err_o(timeout_err_o),
  .fail_cnt_o(fail_cnt_o)
);

// File: tb/i2c_busclr_bench.sv
module i2c_busclr_bench;
  localparam int CPU  = 2;
  localparam int PHU  = 3;
  localparam int NP   = 9;
  localparam int TOU  = 10;
  localparam int MR   = 2;
  localparam int AW   = 2;
  localparam int P    = PHU * CPU;
  localparam int TC   = TOU * CPU;
  localparam int NPH  = 1 + 2 * NP + 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start_i = 1'b0;
  logic bus_busy_i = 1'b0;
  logic nack_o, scl_oe_o, sda_oe_o, done_o, reinit_o, timeout_err_o;
  logic [AW-1:0] fail_cnt_o;
  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  i2c_busclr #(
    .CLK_PER_US(CPU), .PHASE_US(PHU), .PULSES(NP),
    .TIMEOUT_US(TOU), .MAX_RETRY(MR), .ATT_W(AW)
  ) u_i2c_busclr (
    .clk(clk), .rst(rst), .start_i(start_i), .bus_busy_i(bus_busy_i),
    .nack_o(nack_o), .scl_oe_o(scl_oe_o), .sda_oe_o(sda_oe_o),
    .done_o(done_o), .reinit_o(reinit_o), .timeout_err_o(timeout_err_o),
    .fail_cnt_o(fail_cnt_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  // Follows a sequence whose launch edge is the next posedge (edge 1).
  task automatic follow_seq(input int inject_at, input int exp_fail);
    for (int n = 1; n <= NPH * P + 2; n++) begin
      @(posedge clk);
      @(negedge clk);
      if (n == 1) start_i = 1'b0;
      if (n == inject_at) start_i = 1'b1;
      if (n == inject_at + 1) start_i = 1'b0;
      if (n <= NPH * P) begin
        int ph = (n - 1) / P;
        int escl = ((ph >= 1 && ph <= 2 * NP && (ph % 2) == 1) || ph == 2 * NP + 1) ? 1 : 0;
        int esda = (ph == 2 * NP + 1 || ph == 2 * NP + 2) ? 1 : 0;
        chk("R2 nack_o during sequence", nack_o, 1);
        chk("R3 scl_oe_o phase pattern", scl_oe_o, escl);
        chk("R4 sda_oe_o phase pattern", sda_oe_o, esda);
        chk("R5 done_o low mid-sequence", done_o, 0);
      end else if (n == NPH * P + 1) begin
        chk("R5 done_o at end", done_o, 1);
        chk("R5 nack_o falls with done", nack_o, 0);
        chk("R4 bus released at end", scl_oe_o + sda_oe_o, 0);
        chk("R7 fail_cnt_o after sequence", fail_cnt_o, exp_fail);
      end else begin
        chk("R5 done_o single cycle", done_o, 0);
        chk("R5 reinit_o follows done", reinit_o, 1);
      end
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog: got 1 expected 0 (run hung)");
    summary();
    $finish;
  end

  initial begin
    step(3);
    rst = 1'b0;
    step(1);
    // R1: reset state
    chk("R1 nack_o", nack_o, 0);
    chk("R1 scl_oe_o", scl_oe_o, 0);
    chk("R1 sda_oe_o", sda_oe_o, 0);
    chk("R1 done_o", done_o, 0);
    chk("R1 reinit_o", reinit_o, 0);
    chk("R1 timeout_err_o", timeout_err_o, 0);
    chk("R1 fail_cnt_o", fail_cnt_o, 0);

    // R2..R6: manual start, bus free, with a start injected mid-run
    start_i = 1'b1;
    follow_seq(5 * P + 2, 0);
    step(1);
    chk("R5 reinit_o single cycle", reinit_o, 0);
    for (int i = 0; i < 2 * P; i++) begin
      chk("R6 no second sequence", nack_o, 0);
      step(1);
    end

    // R8/R7: busy held high, automatic launches until retries are used up
    bus_busy_i = 1'b1;
    for (int a = 1; a <= MR + 1; a++) begin
      step(TC - 1);
      chk("R8 no launch before window", nack_o, 0);
      follow_seq(0, a);
    end

    // R9: window expires with the count saturated
    step(TC - 1);
    chk("R9 timeout_err_o before window", timeout_err_o, 0);
    step(1);
    chk("R9 timeout_err_o raised", timeout_err_o, 1);
    chk("R9 no sequence when exhausted", nack_o, 0);
    step(3 * TC);
    chk("R9 error held, still no sequence", timeout_err_o + 2 * nack_o, 1);
    chk("R7 count saturated", fail_cnt_o, MR + 1);
    bus_busy_i = 1'b0;
    step(1);
    chk("R9 error cleared on idle bus", timeout_err_o, 0);

    // R8: short busy bursts never reach the window
    for (int b = 0; b < 3; b++) begin
      bus_busy_i = 1'b1;
      step(TC - 2);
      bus_busy_i = 1'b0;
      step(1);
      chk("R8 window restarts on idle bus", nack_o, 0);
    end

    // R7: successful manual attempt clears the count
    start_i = 1'b1;
    follow_seq(0, 0);
    step(2);
    chk("R1 quiet after sequence", nack_o + scl_oe_o + sda_oe_o, 0);

    summary();
    $finish;
  end
endmodule